// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR4-style SDRAM interface and takes the memory from power-up to an idle, calibrated state. After a start pulse it holds the device in reset with clock enable low for a settle interval. It then releases reset and, after a further delay, raises clock enable. Next it issues one mode-register-set command for each mode register, lowest index first. It closes with a precharge-all, a refresh and a long ZQ calibration command, and after the calibration wait it raises a done flag.

The values written into the mode registers come from a small writable bank. The bank resets to a usable configuration: burst of eight, CAS latency 16, CAS write latency 14, and multi-purpose-register mode enabled for later training. Software can change any entry while the sequencer is idle. Commands leave on a registered bus made of a command code, a mode-register index, a value and a valid strobe. Every cycle without a command carries NOP.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, `dram_rst_n`, `dram_cke`, `cmd_valid` and `init_done` are 0, and `cmd_code`, `cmd_mr_idx` and `cmd_value` are 0.
- R2: `dram_rst_n` rises exactly SETTLE_CYC clock edges after the edge that accepts `start`. Until then it and `dram_cke` stay low.
- R3: `dram_cke` rises exactly CKE_CYC edges after `dram_rst_n` rises. `dram_cke` is never high while `dram_rst_n` is low.
- R4: Mode-register-set commands (`cmd_code` 1) go out one per register, with `cmd_mr_idx` running 0, 1, ... NUM_MR-1 in ascending order. Each carries in `cmd_value` the bank entry for that index.
- R5: After reset the bank holds these values. Entry 0 has bits [7:3] = 16 (CAS latency) and bits [1:0] = 0 (burst of eight). Entry 2 has bits [7:3] = 14 (CAS write latency). Entry 3 has bit 2 set (multi-purpose-register mode). All other bits and entries are 0.
- R6: After the last mode-register command, the sequencer issues precharge-all (code 2), then refresh (code 3), then ZQ calibration long (code 4), each with index and value 0.
- R7: The first command goes out exactly GAP_CYC edges after `dram_cke` rises. Successive `cmd_valid` strobes are exactly GAP_CYC edges apart, and each strobe lasts one cycle. Every other cycle carries NOP (code 0, index 0, value 0).
- R8: `init_done` rises exactly ZQ_CYC edges after the ZQ calibration strobe. It then stays high, with `dram_rst_n` and `dram_cke` high, until the next accepted start.
- R9: A `start` that arrives while a sequence is running is ignored, and the running sequence continues unchanged.
- R10: A bank write (`mr_we`, `mr_widx`, `mr_wdata`) takes effect when the sequencer is idle or done. A write that arrives while a sequence is running is ignored.
- R11: A `start` after `init_done` restarts the whole sequence. `init_done`, `dram_rst_n` and `dram_cke` drop on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start-of-initialization pulse |
| mr_we | input | 1 | Bank write enable |
| mr_widx | input | IDX_W | Bank entry to write |
| mr_wdata | input | MR_W | Value to write |
| cmd_valid | output | 1 | Command strobe, one cycle per command |
| cmd_code | output | 3 | 0 NOP, 1 mode set, 2 precharge-all, 3 refresh, 4 ZQ long |
| cmd_mr_idx | output | IDX_W | Mode-register index of a mode-set command |
| cmd_value | output | MR_W | Mode-register value of a mode-set command |
| dram_rst_n | output | 1 | Device reset, active low |
| dram_cke | output | 1 | Device clock enable |
| init_done | output | 1 | Initialization complete |

## Verification
The assertions take for granted that `rst` is applied before the first start and that the timing parameters are at least one cycle each. They also assume the device-side outputs only matter from the first clock after reset. The bench keeps within these bounds by holding reset for several cycles and using a small timing set. It drives every input half a cycle away from the active edge. It pulses `start` and `mr_we` while busy only at chosen points: one during the settle wait and one in the middle of the mode-register commands. Against each of these it compares every output on every cycle with a schedule computed from the parameters.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MRS  = 3'd1,
    CMD_PREA = 3'd2,
    CMD_REF  = 3'd3,
    CMD_ZQCL = 3'd4
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SETTLE,
    ST_CKE,
    ST_SEQ,
    ST_ZQWAIT,
    ST_READY
  } init_state_e;

  // Reset value of a mode-register bank entry
  function automatic logic [15:0] mr_default(input int idx, input int cl, input int cwl);
    logic [15:0] v;
    v = '0;
    case (idx)
      0: begin
        v[7:3] = 5'(cl);
        v[1:0] = 2'b00;
      end
      2: v[7:3] = 5'(cwl);
      3: v[2] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/mr_bank.sv
module mr_bank
  import dram_init_pkg::*;
#(
  parameter int NUM_MR     = 7,
  parameter int MR_W       = 14,
  parameter int IDX_W      = 3,
  parameter int CAS_LAT    = 16,
  parameter int CAS_WR_LAT = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [MR_W-1:0]  wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [MR_W-1:0]  rdata
);

  logic [MR_W-1:0] regs [NUM_MR];

  for (genvar g = 0; g < NUM_MR; g++) begin : g_entry
    localparam logic [15:0] DEF16 = mr_default(g, CAS_LAT, CAS_WR_LAT);
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= DEF16[MR_W-1:0];
      end else if (we && (int'(widx) == g)) begin
        regs[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_MR; i++) begin
      if (int'(ridx) == i) rdata = regs[i];
    end
  end

endmodule

// File: rtl/init_fsm.sv
module init_fsm
  import dram_init_pkg::*;
#(
  parameter int NUM_MR     = 7,
  parameter int MR_W       = 14,
  parameter int IDX_W      = 3,
  parameter int STEP_W     = 4,
  parameter int TW         = 16,
  parameter int SETTLE_CYC = 20000,
  parameter int CKE_CYC    = 100,
  parameter int GAP_CYC    = 8,
  parameter int ZQ_CYC     = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic [IDX_W-1:0] mr_ridx,
  input  logic [MR_W-1:0]  mr_rdata,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  output logic [IDX_W-1:0] cmd_mr_idx,
  output logic [MR_W-1:0]  cmd_value,
  output logic             dram_rst_n,
  output logic             dram_cke,
  output logic             init_done,
  output logic             busy
);

  localparam logic [STEP_W-1:0] STEP_PREA = STEP_W'(NUM_MR);
  localparam logic [STEP_W-1:0] STEP_REF  = STEP_W'(NUM_MR + 1);
  localparam logic [STEP_W-1:0] STEP_ZQ   = STEP_W'(NUM_MR + 2);

  init_state_e       state;
  logic [STEP_W-1:0] step;

  assign busy    = (state != ST_OFF) && (state != ST_READY);
  assign mr_ridx = IDX_W'(step);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_OFF, ST_READY: begin
        if (start) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYC - 1);
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(CKE_CYC - 1);
        end
      end
      ST_CKE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(GAP_CYC - 1);
        end
      end
      ST_SEQ: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = (step == STEP_ZQ) ? TW'(ZQ_CYC - 1) : TW'(GAP_CYC - 1);
        end
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      step       <= '0;
      cmd_valid  <= 1'b0;
      cmd_code   <= CMD_NOP;
      cmd_mr_idx <= '0;
      cmd_value  <= '0;
      dram_rst_n <= 1'b0;
      dram_cke   <= 1'b0;
      init_done  <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      cmd_code   <= CMD_NOP;
      cmd_mr_idx <= '0;
      cmd_value  <= '0;
      case (state)
        ST_OFF, ST_READY: begin
          if (start) begin
            state      <= ST_SETTLE;
            step       <= '0;
            dram_rst_n <= 1'b0;
            dram_cke   <= 1'b0;
            init_done  <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            dram_rst_n <= 1'b1;
            state      <= ST_CKE;
          end
        end
        ST_CKE: begin
          if (tmr_zero) begin
            dram_cke <= 1'b1;
            state    <= ST_SEQ;
          end
        end
        ST_SEQ: begin
          if (tmr_zero) begin
            cmd_valid <= 1'b1;
            step      <= step + 1'b1;
            if (step < STEP_PREA) begin
              cmd_code   <= CMD_MRS;
              cmd_mr_idx <= IDX_W'(step);
              cmd_value  <= mr_rdata;
            end else if (step == STEP_PREA) begin
              cmd_code <= CMD_PREA;
            end else if (step == STEP_REF) begin
              cmd_code <= CMD_REF;
            end else begin
              cmd_code <= CMD_ZQCL;
              state    <= ST_ZQWAIT;
            end
          end
        end
        ST_ZQWAIT: begin
          if (tmr_zero) begin
            init_done <= 1'b1;
            state     <= ST_READY;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  // R7
  cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (dram_rst_n && dram_cke));

  // R3
  cke_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    dram_cke |-> dram_rst_n);

  // R8
  done_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (init_done && !start) |=> init_done);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && dram_rst_n) |=> dram_rst_n);

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int NUM_MR     = 7,
  parameter int MR_W       = 14,
  parameter int CLK_MHZ    = 200,
  parameter int SETTLE_CYC = 100 * CLK_MHZ,
  parameter int CKE_CYC    = 100,
  parameter int GAP_CYC    = 8,
  parameter int ZQ_CYC     = 512,
  parameter int CAS_LAT    = 16,
  parameter int CAS_WR_LAT = 14,
  localparam int IDX_W     = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mr_we,
  input  logic [IDX_W-1:0] mr_widx,
  input  logic [MR_W-1:0]  mr_wdata,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  output logic [IDX_W-1:0] cmd_mr_idx,
  output logic [MR_W-1:0]  cmd_value,
  output logic             dram_rst_n,
  output logic             dram_cke,
  output logic             init_done
);

  localparam int STEP_W = $clog2(NUM_MR + 3);
  localparam int MAX_A  = (SETTLE_CYC > CKE_CYC) ? SETTLE_CYC : CKE_CYC;
  localparam int MAX_B  = (GAP_CYC > ZQ_CYC) ? GAP_CYC : ZQ_CYC;
  localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW     = $clog2(MAX_T + 1);
  localparam int GW     = $clog2(GAP_CYC + 1);

  logic             busy;
  logic             tmr_load;
  logic [TW-1:0]    tmr_val;
  logic             tmr_zero;
  logic [IDX_W-1:0] mr_ridx;
  logic [MR_W-1:0]  mr_rdata;

  mr_bank #(
    .NUM_MR(NUM_MR), .MR_W(MR_W), .IDX_W(IDX_W),
    .CAS_LAT(CAS_LAT), .CAS_WR_LAT(CAS_WR_LAT)
  ) u_bank (
    .clk(clk), .rst(rst),
    .we(mr_we && !busy), .widx(mr_widx), .wdata(mr_wdata),
    .ridx(mr_ridx), .rdata(mr_rdata)
  );

  init_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst),
    .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  init_fsm #(
    .NUM_MR(NUM_MR), .MR_W(MR_W), .IDX_W(IDX_W), .STEP_W(STEP_W), .TW(TW),
    .SETTLE_CYC(SETTLE_CYC), .CKE_CYC(CKE_CYC), .GAP_CYC(GAP_CYC), .ZQ_CYC(ZQ_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .mr_ridx(mr_ridx), .mr_rdata(mr_rdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_mr_idx(cmd_mr_idx),
    .cmd_value(cmd_value), .dram_rst_n(dram_rst_n), .dram_cke(dram_cke),
    .init_done(init_done), .busy(busy)
  );

  // Checking state observed at the command bus
  logic [STEP_W-1:0] mrs_seen;
  logic [GW-1:0]     since_cmd;
  logic              zq_seen;

  always_ff @(posedge clk) begin
    if (rst || !dram_rst_n) begin
      mrs_seen  <= '0;
      since_cmd <= GW'(GAP_CYC);
      zq_seen   <= 1'b0;
    end else begin
      if (cmd_valid && cmd_code == CMD_MRS) mrs_seen <= mrs_seen + 1'b1;
      if (cmd_valid && cmd_code == CMD_ZQCL) zq_seen <= 1'b1;
      if (cmd_valid) since_cmd <= GW'(1);
      else if (since_cmd != GW'(GAP_CYC)) since_cmd <= since_cmd + 1'b1;
    end
  end

  // R4
  mrs_ascending_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_MRS) |-> (STEP_W'(cmd_mr_idx) == mrs_seen));

  // R6
  prea_after_all_mrs_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_PREA) |-> (mrs_seen == STEP_W'(NUM_MR)));

  // R7
  cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (since_cmd == GW'(GAP_CYC)));

  // R8
  done_after_zq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> zq_seen);

endmodule

// File: tb/dram_init_seq_bench.sv
module dram_init_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NMR = 7;
  localparam int MRW = 14;
  localparam int S   = 20;
  localparam int C   = 5;
  localparam int G   = 4;
  localparam int Z   = 16;
  localparam int IW  = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           mr_we = 1'b0;
  logic [IW-1:0]  mr_widx = '0;
  logic [MRW-1:0] mr_wdata = '0;
  logic           cmd_valid;
  logic [2:0]     cmd_code;
  logic [IW-1:0]  cmd_mr_idx;
  logic [MRW-1:0] cmd_value;
  logic           dram_rst_n;
  logic           dram_cke;
  logic           init_done;

  int total = 0;
  int bad   = 0;
  int exp_mr [NMR];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_init_seq #(
    .NUM_MR(NMR), .MR_W(MRW), .SETTLE_CYC(S), .CKE_CYC(C), .GAP_CYC(G), .ZQ_CYC(Z)
  ) u_dram_init_seq (
    .clk(clk), .rst(rst), .start(start),
    .mr_we(mr_we), .mr_widx(mr_widx), .mr_wdata(mr_wdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_mr_idx(cmd_mr_idx),
    .cmd_value(cmd_value), .dram_rst_n(dram_rst_n), .dram_cke(dram_cke),
    .init_done(init_done)
  );

  task automatic check(input int got, input int expv, input string tag);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, expv);
    end
  endtask

  task automatic check_quiet(input string tag);
    check(int'(cmd_valid), 0, {tag, " valid"});
    check(int'(cmd_code), 0, {tag, " code"});
    check(int'(cmd_mr_idx), 0, {tag, " idx"});
    check(int'(cmd_value), 0, {tag, " value"});
  endtask

  task automatic write_mr(input int idx, input int val);
    @(negedge clk);
    mr_we = 1'b1; mr_widx = IW'(idx); mr_wdata = MRW'(val);
    @(negedge clk);
    mr_we = 1'b0;
    exp_mr[idx] = val & ((1 << MRW) - 1);
  endtask

  // One full sequence; inj_s / inj_w give cycles for a busy start / busy write
  task automatic run_seq(input int inj_s, input int inj_w);
    int base, nz, last;
    base = S + C;
    nz   = base + G * (NMR + 3);
    last = nz + Z + 3;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= last; n++) begin
      int k, ev, ec, ei, eval;
      start = (n == inj_s);
      mr_we = (n == inj_w);
      mr_widx = IW'(3);
      mr_wdata = MRW'(14'h3FFF);
      // R2 R11: reset held for S edges, released after
      check(int'(dram_rst_n), (n >= S) ? 1 : 0, "R2 dram_rst_n");
      // R3
      check(int'(dram_cke), (n >= S + C) ? 1 : 0, "R3 dram_cke");
      ev = 0; ec = 0; ei = 0; eval = 0;
      if (n > base && ((n - base) % G) == 0) begin
        k = (n - base) / G - 1;
        if (k <= NMR + 2) begin
          ev = 1;
          if (k < NMR) begin ec = 1; ei = k; eval = exp_mr[k]; end
          else if (k == NMR) ec = 2;
          else if (k == NMR + 1) ec = 3;
          else ec = 4;
        end
      end
      // R7 strobe timing and NOP cycles
      check(int'(cmd_valid), ev, "R7 cmd_valid");
      // R4 R6 command order
      check(int'(cmd_code), ec, "R4/R6 cmd_code");
      check(int'(cmd_mr_idx), ei, "R4 cmd_mr_idx");
      // R5 R10 value from bank
      check(int'(cmd_value), eval, "R10 cmd_value");
      // R8
      check(int'(init_done), (n >= nz + Z) ? 1 : 0, "R8 init_done");
      @(negedge clk);
    end
    start = 1'b0;
    mr_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R5 defaults computed from the field layout
    for (int i = 0; i < NMR; i++) exp_mr[i] = 0;
    exp_mr[0] = 16 * 8;
    exp_mr[2] = 14 * 8;
    exp_mr[3] = 4;

    repeat (4) @(negedge clk);
    // R1 during reset
    check(int'(dram_rst_n), 0, "R1 dram_rst_n in reset");
    check(int'(dram_cke), 0, "R1 dram_cke in reset");
    check(int'(init_done), 0, "R1 init_done in reset");
    check_quiet("R1 reset");
    rst = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(int'(dram_rst_n), 0, "R1 dram_rst_n idle");
      check(int'(dram_cke), 0, "R1 dram_cke idle");
      check(int'(init_done), 0, "R1 init_done idle");
      check_quiet("R1 idle");
    end

    // R4 R5 R6 R7 R8 with reset defaults
    run_seq(-1, -1);
    // R9 start during settle; R11 restart from done
    run_seq(3, -1);
    // R9 start among mode-set commands; R10 write during settle ignored
    run_seq(S + C + 2 * G + 1, 10);
    // R10 write during mode-set commands ignored
    run_seq(-1, S + C + G + 1);

    // R10 R4 sweep of bank contents
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NMR; i++) write_mr(i, (i + 1) * 165 + r * 785);
      run_seq(-1, -1);
    end

    // R8 done holds while idle
    repeat (6) begin
      @(negedge clk);
      check(int'(init_done), 1, "R8 init_done hold");
      check(int'(dram_cke), 1, "R8 dram_cke hold");
      check_quiet("R7 idle after done");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule